// File: doc/BRIEF.md
# Phase-Tagged Completion Queue Writer

This block turns completion events into 16-byte records in a circular completion ring that lives in host memory. Each record is emitted as one request on a simple memory-write port. The request address is the ring base plus sixteen times the current slot. The data carries the work-queue slot index, the byte length and a phase bit. When the write is acknowledged, the producer pointer advances and a one-cycle interrupt request is raised.

The record has no separate valid flag. The top bit of the last dword is a phase bit, and it flips each time the producer pointer wraps the ring. The host compares that bit with the wrap parity of its own consumer pointer. An entry whose phase equals that parity is empty; any other entry is new. The host writes its consumer pointer back to the block. The block compares it with its producer pointer and refuses new completions while the ring holds a full set of unread entries.

Completions are written one at a time, in the order they are accepted, at consecutive slots. This keeps them in one-to-one order with the descriptors of the work queue they complete.

Top module: `cq_phase_writer`

## Requirements
- R1: After reset the producer pointer is 0, no write request is pending, the interrupt output is low, and completion input ready is high while the consumer pointer is 0.
- R2: A record write targets address base + 16 * slot, where slot is the producer pointer modulo the ring size 2^LOG_SIZE. Successive completions land in successive slots, wrapping from the last slot to slot 0.
- R3: The record is four little-endian dwords on a 128-bit data bus, with dword k in bits 32k+31..32k:
  - dword 0 holds the work-queue slot index in bits 15:0 and zero in bits 31:16;
  - dword 1 holds the byte length;
  - dword 2 is zero;
  - dword 3 is zero in bits 30:0.
- R4: Bit 31 of dword 3 (bus bit 127) is the inverse of bit LOG_SIZE of the producer pointer: 1 during the first pass through the ring, 0 during the second pass, and so on alternately.
- R5: Once the write request is raised, it stays raised with address and data unchanged until the port accepts it (valid and ready both high).
- R6: Only one completion is in flight. Input ready stays low from acceptance of a completion until its write is acknowledged. The producer pointer advances by exactly one in the cycle after the acknowledge.
- R7: While producer pointer minus consumer pointer (modulo 2^PTR_W) is at least the ring size, input ready is low and no completion is accepted. Ready rises in the same cycle that the consumer pointer input moves to make room.
- R8: In the cycle after an acknowledged write, the interrupt output is high for exactly one cycle, unless the interrupt mask input was high in the acknowledge cycle; in that case the output stays low.
- R9: A write acknowledge that arrives while no write is outstanding is ignored: the producer pointer does not change and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of slot 0 of the ring |
| cons_ptr | input | PTR_W | Consumer pointer written by the host |
| irq_mask | input | 1 | Suppresses the interrupt pulse when high |
| cpl_valid | input | 1 | A completion is offered |
| cpl_ready | output | 1 | Completion accepted when high together with cpl_valid |
| cpl_wq_idx | input | 16 | Work-queue slot index of the completion |
| cpl_len | input | 32 | Byte length of the completion |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Port accepts the request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 128 | Record, dword 0 in the low bits |
| wr_done | input | 1 | One-cycle acknowledge of the accepted write |
| prod_ptr | output | PTR_W | Producer pointer |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Two pairs of events can fall in the same clock cycle.

The first pair is the interrupt pulse of one record and the acceptance of the next completion. The bench holds the next completion valid during the acknowledge cycle. It then checks that the interrupt is high and input ready is high in the same following cycle, and that the new write request appears one cycle later with the next slot.

The second pair is a full ring with a completion waiting and the host advancing its consumer pointer. The bench fills an eight-slot ring across its wrap point. It holds an offer against the full ring and checks that ready stays low. It then moves the consumer pointer and checks that ready rises combinationally in that same cycle. Finally it checks that the accepted record lands at slot 0 with phase 0.

// File: rtl/cqw_pkg.sv
// Package: shared constants and types for the completion queue writer.
// Assumes a fixed 16-byte record made of four 32-bit dwords.
package cqw_pkg;

    localparam int DW_BITS    = 32;
    localparam int REC_DWORDS = 4;
    localparam int REC_BITS   = DW_BITS * REC_DWORDS;
    localparam int REC_SHIFT  = 4;   // log2 of record bytes
    localparam int IDX_BITS   = 16;
    localparam int LEN_BITS   = 32;
    localparam int PHASE_BIT  = DW_BITS - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } cqw_state_e;

endpackage

// File: rtl/cqw_ring_track.sv
// Module: cqw_ring_track
// Holds the producer pointer and derives the slot, the phase and the full flag.
// Assumes PTR_W > LOG_SIZE, so that the pointers carry wrap parity above the slot bits.
module cqw_ring_track #(
    parameter int LOG_SIZE = 8,
    parameter int PTR_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic [PTR_W-1:0]    cons_ptr,
    output logic [PTR_W-1:0]    prod_ptr,
    output logic [LOG_SIZE-1:0] slot,
    output logic                phase,
    output logic                full
);

    localparam logic [PTR_W-1:0] RING_ENTRIES = {{(PTR_W-1){1'b0}}, 1'b1} << LOG_SIZE;

    logic [PTR_W-1:0] occupancy;

    // Advance the producer pointer once per acknowledged record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_ptr <= '0;
        end else if (advance) begin
            prod_ptr <= prod_ptr + {{(PTR_W-1){1'b0}}, 1'b1};
        end
    end

    // Derive the slot, the phase and the fill level from the pointers.
    always_comb begin
        occupancy = prod_ptr - cons_ptr;
        full      = (occupancy >= RING_ENTRIES);
        slot      = prod_ptr[LOG_SIZE-1:0];
        phase     = ~prod_ptr[LOG_SIZE];
    end

endmodule

// File: rtl/cqw_rec_build.sv
// Module: cqw_rec_build
// Forms the write address and the 128-bit record from the slot, phase and captured fields.
// Assumes ADDR_W > LOG_SIZE + 4; the ring base need not be aligned.
module cqw_rec_build
    import cqw_pkg::*;
#(
    parameter int LOG_SIZE = 8,
    parameter int ADDR_W   = 64
) (
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic [LOG_SIZE-1:0] slot,
    input  logic                phase,
    input  logic [IDX_BITS-1:0] wq_idx,
    input  logic [LEN_BITS-1:0] len,
    output logic [ADDR_W-1:0]   addr,
    output logic [REC_BITS-1:0] data
);

    logic [ADDR_W-1:0]  slot_offset;
    logic [DW_BITS-1:0] dword [REC_DWORDS];

    // Scale the slot by the record size and add it to the base.
    always_comb begin
        slot_offset = '0;
        slot_offset[LOG_SIZE+REC_SHIFT-1:0] = {slot, {REC_SHIFT{1'b0}}};
        addr = ring_base + slot_offset;
    end

    // Fill the four dwords of the record.
    always_comb begin
        dword[0] = {{(DW_BITS-IDX_BITS){1'b0}}, wq_idx};
        dword[1] = len;
        dword[2] = '0;
        dword[3] = '0;
        dword[3][PHASE_BIT] = phase;
    end

    // Place the dwords on the bus, dword 0 in the low bits.
    for (genvar g = 0; g < REC_DWORDS; g++) begin : g_pack
        assign data[g*DW_BITS +: DW_BITS] = dword[g];
    end

endmodule

// File: rtl/cqw_seq.sv
// Module: cqw_seq
// Sequences one completion at a time: accept, request the write, wait for the acknowledge, raise the interrupt.
// Assumes wr_done is a one-cycle pulse that follows the accepted request.
module cqw_seq
    import cqw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ring_full,
    input  logic                irq_mask,
    input  logic                cpl_valid,
    output logic                cpl_ready,
    input  logic [IDX_BITS-1:0] cpl_wq_idx,
    input  logic [LEN_BITS-1:0] cpl_len,
    output logic                wr_valid,
    input  logic                wr_ready,
    input  logic                wr_done,
    output logic                advance,
    output logic [IDX_BITS-1:0] cap_idx,
    output logic [LEN_BITS-1:0] cap_len,
    output logic                irq
);

    cqw_state_e state;

    // Step the controller and capture the accepted completion fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cap_idx <= '0;
            cap_len <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cpl_valid && cpl_ready) begin
                        cap_idx <= cpl_wq_idx;
                        cap_len <= cpl_len;
                        state   <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (wr_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wr_done) begin
                        irq   <= ~irq_mask;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshakes from the controller state.
    always_comb begin
        cpl_ready = (state == ST_IDLE) && !ring_full;
        wr_valid  = (state == ST_REQ);
        advance   = (state == ST_WAIT) && wr_done;
    end

endmodule

// File: rtl/cq_phase_writer.sv
// Module: cq_phase_writer
// Top: writes phase-tagged 16-byte completion records into a host ring and raises an interrupt per record.
// Assumes the host owns cons_ptr and moves it forward only over consumed entries.
module cq_phase_writer
    import cqw_pkg::*;
#(
    parameter int LOG_SIZE = 8,
    parameter int PTR_W    = 16,
    parameter int ADDR_W   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic [PTR_W-1:0]    cons_ptr,
    input  logic                irq_mask,
    input  logic                cpl_valid,
    output logic                cpl_ready,
    input  logic [15:0]         cpl_wq_idx,
    input  logic [31:0]         cpl_len,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [127:0]        wr_data,
    input  logic                wr_done,
    output logic [PTR_W-1:0]    prod_ptr,
    output logic                irq
);

    logic                advance;
    logic                ring_full;
    logic                phase;
    logic [LOG_SIZE-1:0] slot;
    logic [IDX_BITS-1:0] cap_idx;
    logic [LEN_BITS-1:0] cap_len;

    cqw_ring_track #(
        .LOG_SIZE (LOG_SIZE),
        .PTR_W    (PTR_W)
    ) i_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .cons_ptr (cons_ptr),
        .prod_ptr (prod_ptr),
        .slot     (slot),
        .phase    (phase),
        .full     (ring_full)
    );

    cqw_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_full  (ring_full),
        .irq_mask   (irq_mask),
        .cpl_valid  (cpl_valid),
        .cpl_ready  (cpl_ready),
        .cpl_wq_idx (cpl_wq_idx),
        .cpl_len    (cpl_len),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_done    (wr_done),
        .advance    (advance),
        .cap_idx    (cap_idx),
        .cap_len    (cap_len),
        .irq        (irq)
    );

    cqw_rec_build #(
        .LOG_SIZE (LOG_SIZE),
        .ADDR_W   (ADDR_W)
    ) i_rec (
        .ring_base (ring_base),
        .slot      (slot),
        .phase     (phase),
        .wq_idx    (cap_idx),
        .len       (cap_len),
        .addr      (wr_addr),
        .data      (wr_data)
    );

endmodule

// File: rtl/cqw_checker.sv
// Module: cqw_checker
// Temporal checks on the ports of cq_phase_writer, attached through bind.
module cqw_checker #(
    parameter int LOG_SIZE = 8,
    parameter int PTR_W    = 16,
    parameter int ADDR_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PTR_W-1:0]  cons_ptr,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [127:0]      wr_data,
    input logic [PTR_W-1:0]  prod_ptr,
    input logic              irq
);

    localparam logic [PTR_W-1:0] RING_ENTRIES = {{(PTR_W-1){1'b0}}, 1'b1} << LOG_SIZE;

    logic [PTR_W-1:0] fill;
    assign fill = prod_ptr - cons_ptr;

    AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[127] == ~prod_ptr[LOG_SIZE])); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R5

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cpl_ready); // R6

    AST_PROD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_ptr != $past(prod_ptr)) |-> (prod_ptr == $past(prod_ptr) + {{(PTR_W-1){1'b0}}, 1'b1})); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |-> (fill < RING_ENTRIES)); // R7

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

endmodule

bind cq_phase_writer cqw_checker #(
    .LOG_SIZE (LOG_SIZE),
    .PTR_W    (PTR_W),
    .ADDR_W   (ADDR_W)
) i_cqw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cons_ptr  (cons_ptr),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .prod_ptr  (prod_ptr),
    .irq       (irq)
);

// File: tb/test_cq_phase_writer.sv
module test_cq_phase_writer;

    localparam int CLK_PERIOD = 10;
    localparam int LOG_SIZE   = 3;
    localparam int PTR_W      = 16;
    localparam int ADDR_W     = 64;
    localparam int RING       = 1 << LOG_SIZE;
    localparam logic [ADDR_W-1:0] BASE = 64'h0000_0001_2345_6700;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_base = BASE;
    logic [PTR_W-1:0]  cons_ptr = '0;
    logic              irq_mask = 1'b0;
    logic              cpl_valid = 1'b0;
    logic              cpl_ready;
    logic [15:0]       cpl_wq_idx = '0;
    logic [31:0]       cpl_len = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [127:0]      wr_data;
    logic              wr_done = 1'b0;
    logic [PTR_W-1:0]  prod_ptr;
    logic              irq;

    int checks = 0;
    int failures = 0;
    int exp_prod = 0;

    cq_phase_writer #(
        .LOG_SIZE (LOG_SIZE),
        .PTR_W    (PTR_W),
        .ADDR_W   (ADDR_W)
    ) i_cq_phase_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_base  (ring_base),
        .cons_ptr   (cons_ptr),
        .irq_mask   (irq_mask),
        .cpl_valid  (cpl_valid),
        .cpl_ready  (cpl_ready),
        .cpl_wq_idx (cpl_wq_idx),
        .cpl_len    (cpl_len),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_done    (wr_done),
        .prod_ptr   (prod_ptr),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_record(input int p, input logic [15:0] idx, input logic [31:0] len);
        logic ph;
        ph = ~p[LOG_SIZE];
        return {ph, 31'b0, 32'b0, len, 16'b0, idx};
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input int p);
        return BASE + ADDR_W'((p % RING) * 16);
    endfunction

    // Offer a completion and wait until it is accepted; ends at the negedge after acceptance.
    task automatic offer(input logic [15:0] idx, input logic [31:0] len);
        cpl_valid  = 1'b1;
        cpl_wq_idx = idx;
        cpl_len    = len;
        while (!cpl_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // Check the write request, stall it, accept and acknowledge it, then check pointer and interrupt.
    task automatic finish(input logic [15:0] idx, input logic [31:0] len, input int stall,
                          input bit mask, input bit chain, input logic [15:0] nidx, input logic [31:0] nlen);
        logic [127:0] rec;
        rec = exp_record(exp_prod, idx, len);
        check(wr_valid == 1'b1, "R6 request raised", 128'(wr_valid), 128'd1);
        check(wr_addr == exp_addr(exp_prod), "R2 address", 128'(wr_addr), 128'(exp_addr(exp_prod)));
        check(wr_data == rec, "R3 R4 record", wr_data, rec);
        check(cpl_ready == 1'b0, "R6 ready low in flight", 128'(cpl_ready), 128'd0);
        for (int s = 0; s < stall; s++) begin
            @(posedge clk);
            @(negedge clk);
            check(wr_valid && wr_addr == exp_addr(exp_prod) && wr_data == rec, "R5 held request",
                  wr_data, rec);
        end
        wr_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_ready = 1'b0;
        check(wr_valid == 1'b0, "R6 request dropped after accept", 128'(wr_valid), 128'd0);
        check(prod_ptr == PTR_W'(exp_prod), "R6 no advance before ack", 128'(prod_ptr), 128'(exp_prod));
        irq_mask = mask;
        wr_done  = 1'b1;
        if (chain) begin
            cpl_valid  = 1'b1;
            cpl_wq_idx = nidx;
            cpl_len    = nlen;
        end
        @(posedge clk);
        @(negedge clk);
        wr_done  = 1'b0;
        irq_mask = 1'b0;
        exp_prod++;
        check(prod_ptr == PTR_W'(exp_prod), "R6 advance after ack", 128'(prod_ptr), 128'(exp_prod));
        check(irq == !mask, "R8 interrupt after ack", 128'(irq), 128'(!mask));
    endtask

    task automatic irq_gone();
        @(posedge clk);
        @(negedge clk);
        check(irq == 1'b0, "R8 one-cycle interrupt", 128'(irq), 128'd0);
    endtask

    task automatic t_reset();
        check(prod_ptr == '0, "R1 producer pointer", 128'(prod_ptr), 128'd0);
        check(wr_valid == 1'b0, "R1 no request", 128'(wr_valid), 128'd0);
        check(irq == 1'b0, "R1 no interrupt", 128'(irq), 128'd0);
        check(cpl_ready == 1'b1, "R1 ready", 128'(cpl_ready), 128'd1);
    endtask

    task automatic t_basic();
        offer(16'h0003, 32'd64);
        finish(16'h0003, 32'd64, 0, 1'b0, 1'b0, 16'h0, 32'h0);
        irq_gone();
        offer(16'hBEEF, 32'd1514);
        finish(16'hBEEF, 32'd1514, 3, 1'b0, 1'b0, 16'h0, 32'h0);
        irq_gone();
    endtask

    task automatic t_masked();
        offer(16'h0102, 32'hFFFF_FFFF);
        finish(16'h0102, 32'hFFFF_FFFF, 1, 1'b1, 1'b0, 16'h0, 32'h0);
        irq_gone();
    endtask

    task automatic t_stray_done();
        wr_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_done = 1'b0;
        check(prod_ptr == PTR_W'(exp_prod), "R9 stray ack no advance", 128'(prod_ptr), 128'(exp_prod));
        check(irq == 1'b0, "R9 stray ack no interrupt", 128'(irq), 128'd0);
    endtask

    task automatic t_back_to_back();
        offer(16'h0010, 32'd100);
        finish(16'h0010, 32'd100, 0, 1'b0, 1'b1, 16'h0011, 32'd200);
        check(cpl_ready == 1'b1, "R8 R6 ready beside interrupt", 128'(cpl_ready), 128'd1);
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
        check(irq == 1'b0, "R8 pulse ends on accept", 128'(irq), 128'd0);
        finish(16'h0011, 32'd200, 0, 1'b0, 1'b0, 16'h0, 32'h0);
        irq_gone();
    endtask

    task automatic t_full_wrap();
        while (exp_prod - int'(cons_ptr) < RING) begin
            offer(16'(exp_prod), 32'(exp_prod * 3 + 1));
            finish(16'(exp_prod), 32'(exp_prod * 3 + 1), 0, 1'b0, 1'b0, 16'h0, 32'h0);
        end
        cpl_valid  = 1'b1;
        cpl_wq_idx = 16'h0777;
        cpl_len    = 32'd42;
        for (int k = 0; k < 3; k++) begin
            check(cpl_ready == 1'b0, "R7 ready low when full", 128'(cpl_ready), 128'd0);
            @(posedge clk);
            @(negedge clk);
        end
        check(wr_valid == 1'b0, "R7 nothing written when full", 128'(wr_valid), 128'd0);
        cons_ptr = cons_ptr + 1'b1;
        #1;
        check(cpl_ready == 1'b1, "R7 ready on consumer move", 128'(cpl_ready), 128'd1);
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
        check(wr_addr == BASE, "R2 wrap to slot 0", 128'(wr_addr), 128'(BASE));
        check(wr_data[127] == 1'b0, "R4 second pass phase 0", 128'(wr_data[127]), 128'd0);
        finish(16'h0777, 32'd42, 0, 1'b0, 1'b0, 16'h0, 32'h0);
        irq_gone();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_masked();
        t_stray_done();
        t_back_to_back();
        t_full_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule